// File: doc/BRIEF.md
# Converter Serial Configuration and Result Port

This block is the digital serial port of a sampling converter. A rising edge on the convert line opens a new phase. The port then captures the previous conversion result from a parallel input and shifts it out MSB first on the serial data output, one bit for each falling edge of the serial clock. In the same frame the host shifts in a 14-bit configuration word on the serial data input, one bit for each rising serial clock edge.

The first input bit of a frame is an update flag. If the flag is low, the rest of the input frame is ignored. If it is high and all 14 bits arrive, the word is staged. A staged word becomes the active configuration at the next convert rising edge, and a one-cycle strobe marks that moment. The active configuration has a readback bit. When that bit is set, the 14 active configuration bits follow the result on the serial output and the output stays enabled for 30 falling edges instead of 16.

The port also latches the busy-indicator selection at each end-of-conversion pulse. All serial inputs are sampled in the system clock domain through synchronisers, so the serial clock must be slow compared with the system clock.

Top module: `adc_cfg_port`

## Requirements
- R1: While reset is asserted and after it is released, `sdo_oe_o`, `sdo_o`, `cfg_upd_o` and `busy_sel_o` are 0, and `cfg_o` equals the parameter `CFG_RST` (default 0).
- R2: A rising edge on `cnv_i` captures `result_i` and raises `sdo_oe_o`. `sdo_o` then shows result bit 15, and after k falling `sck_i` edges it shows result bit 15-k.
- R3: When bit 0 of the active configuration is 0 (readback off), `sdo_oe_o` falls on the 16th falling `sck_i` edge of the frame.
- R4: When bit 0 of the active configuration is 1 (readback on), falling edges 16 to 29 present the active configuration on `sdo_o`, bit 13 first, and `sdo_oe_o` falls on the 30th edge.
- R5: The first `din_i` bit of a frame, sampled on a rising `sck_i` edge, is the update flag. If it is 0, no `din_i` bit of that frame can change `cfg_o`.
- R6: If the flag is 1, the 14 bits on the first 14 rising edges (flag as bit 13, MSB first) are staged as a whole. A frame that ends with fewer than 14 rising edges stages nothing.
- R7: A staged word is loaded into `cfg_o` at the next `cnv_i` rising edge, never within the frame that wrote it. In that cycle `cfg_upd_o` pulses high for exactly one clock. `cfg_o` never changes without this strobe.
- R8: Falling `sck_i` edges after the frame limit are ignored: `sdo_oe_o` stays 0 and `sdo_o` stays 0 until the next `cnv_i` rising edge.
- R9: On an `eoc_i` pulse, `busy_sel_o` becomes 1 if `cnv_i` is low and 0 if `cnv_i` is high, so that holding `cnv_i` high before the end of conversion suppresses the busy indicator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert line; a rising edge opens a phase |
| sck_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial configuration data from the host |
| eoc_i | input | 1 | One-cycle end-of-conversion pulse |
| result_i | input | 16 | Conversion result to be shifted out |
| sdo_o | output | 1 | Serial result/readback data (0 when not driven) |
| sdo_oe_o | output | 1 | Enable for the serial output driver |
| cfg_o | output | 14 | Active configuration word |
| cfg_upd_o | output | 1 | One-cycle strobe when a new configuration is committed |
| busy_sel_o | output | 1 | 1 when the busy-indicator mode is selected |

## Verification
On every cycle, the assertions check that the output is quiet whenever its enable is low, that the falling-edge count stays within the frame limit, and that the enable is released only by a serial clock falling edge. They also check that `cfg_o` changes only together with a single-cycle strobe, that every committed word carries its flag bit, and that the busy selection follows the convert level at end of conversion. Several behaviours need whole frames and are shown only by the bench's frame sequence: the exact bit order of the result and readback, the release point at 16 or 30 edges, the discarding of partial or flag-low writes, and the one-phase delay before a written configuration takes effect.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

  // state of the configuration capture within a frame
  typedef enum logic [1:0] {
    CAP_FLAG  = 2'd0,  // waiting for the update flag bit
    CAP_SHIFT = 2'd1,  // flag was high, collecting bits
    CAP_SKIP  = 2'd2   // flag low or word complete, ignore din
  } cap_state_e;

  // number of falling serial edges for which the output stays driven
  function automatic int unsigned frame_edges(int unsigned res_w,
                                              int unsigned cfg_w,
                                              logic        rb_on);
    return rb_on ? (res_w + cfg_w) : res_w;
  endfunction

  // width of a counter that must hold values 0..n
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/adc_cfg_sync.sv
module adc_cfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign q_o    = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stage_q[STAGES-1] & prev_q;

endmodule

// File: rtl/adc_cfg_capture.sv
module adc_cfg_capture
  import adc_cfg_pkg::*;
#(
  parameter int unsigned CFG_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic             sck_rise_i,
  input  logic             din_i,
  output logic [CFG_W-1:0] stage_o,
  output logic             stage_vld_o
);

  localparam int unsigned RCNT_W = cnt_width(CFG_W);

  cap_state_e        state_q;
  logic [RCNT_W-1:0] bits_q;
  logic [CFG_W-1:0]  shift_q;
  logic              last_bit;

  assign last_bit = (bits_q == RCNT_W'(CFG_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CAP_SKIP;
      bits_q      <= '0;
      shift_q     <= '0;
      stage_o     <= '0;
      stage_vld_o <= 1'b0;
    end else if (frame_start_i) begin
      // new phase: staged word is consumed, partial word dropped
      state_q     <= CAP_FLAG;
      bits_q      <= '0;
      shift_q     <= '0;
      stage_vld_o <= 1'b0;
    end else if (sck_rise_i) begin
      unique case (state_q)
        CAP_FLAG: begin
          bits_q  <= RCNT_W'(1);
          shift_q <= {shift_q[CFG_W-2:0], din_i};
          state_q <= din_i ? CAP_SHIFT : CAP_SKIP;
        end
        CAP_SHIFT: begin
          bits_q  <= bits_q + RCNT_W'(1);
          shift_q <= {shift_q[CFG_W-2:0], din_i};
          if (last_bit) begin
            stage_o     <= {shift_q[CFG_W-2:0], din_i};
            stage_vld_o <= 1'b1;
            state_q     <= CAP_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/adc_cfg_shifter.sv
module adc_cfg_shifter
  import adc_cfg_pkg::*;
#(
  parameter int unsigned FRAME_W = 30,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start_i,
  input  logic               sck_fall_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic [CNT_W-1:0]   limit_i,
  output logic               sdo_o,
  output logic               oe_o,
  output logic [CNT_W-1:0]   edges_o,
  output logic [CNT_W-1:0]   limit_o
);

  logic [FRAME_W-1:0] word_q;
  logic               last_edge;

  assign last_edge = (edges_o == limit_o - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      oe_o    <= 1'b0;
      edges_o <= '0;
      limit_o <= '0;
    end else if (frame_start_i) begin
      word_q  <= word_i;
      oe_o    <= 1'b1;
      edges_o <= '0;
      limit_o <= limit_i;
    end else if (sck_fall_i && oe_o) begin
      word_q  <= {word_q[FRAME_W-2:0], 1'b0};
      edges_o <= edges_o + CNT_W'(1);
      if (last_edge) oe_o <= 1'b0;
    end
  end

  assign sdo_o = oe_o & word_q[FRAME_W-1];

endmodule

// File: rtl/adc_cfg_port.sv
module adc_cfg_port
  import adc_cfg_pkg::*;
#(
  parameter int unsigned RES_W       = 16,
  parameter int unsigned CFG_W       = 14,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RB_BIT      = 0,
  parameter logic [13:0] CFG_RST     = 14'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_i,
  input  logic             sck_i,
  input  logic             din_i,
  input  logic             eoc_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             cfg_upd_o,
  output logic             busy_sel_o
);

  localparam int unsigned FRAME_W = RES_W + CFG_W;
  localparam int unsigned CNT_W   = cnt_width(FRAME_W);

  // synchronised inputs: bit 0 cnv, bit 1 sck, bit 2 din
  logic [2:0] sync_q, sync_rise, sync_fall;
  logic       cnv_rise, sck_rise, sck_fall, din_s;

  adc_cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    ({din_i, sck_i, cnv_i}),
    .q_o    (sync_q),
    .rise_o (sync_rise),
    .fall_o (sync_fall)
  );

  assign cnv_rise = sync_rise[0];
  assign sck_rise = sync_rise[1];
  assign sck_fall = sync_fall[1];
  assign din_s    = sync_q[2];

  // configuration capture
  logic [CFG_W-1:0] stage_w;
  logic             stage_vld;

  adc_cfg_capture #(.CFG_W(CFG_W)) cap_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (cnv_rise),
    .sck_rise_i    (sck_rise),
    .din_i         (din_s),
    .stage_o       (stage_w),
    .stage_vld_o   (stage_vld)
  );

  // configuration that governs the phase now opening
  logic [CFG_W-1:0] cfg_next;
  logic [CNT_W-1:0] limit_next;

  assign cfg_next   = stage_vld ? stage_w : cfg_o;
  assign limit_next = CNT_W'(frame_edges(RES_W, CFG_W, cfg_next[RB_BIT]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o     <= CFG_RST[CFG_W-1:0];
      cfg_upd_o <= 1'b0;
    end else begin
      cfg_upd_o <= cnv_rise & stage_vld;
      if (cnv_rise && stage_vld) cfg_o <= stage_w;
    end
  end

  // serial output
  logic [CNT_W-1:0] edge_cnt, edge_lim;

  adc_cfg_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) shf_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (cnv_rise),
    .sck_fall_i    (sck_fall),
    .word_i        ({result_i, cfg_next}),
    .limit_i       (limit_next),
    .sdo_o         (sdo_o),
    .oe_o          (sdo_oe_o),
    .edges_o       (edge_cnt),
    .limit_o       (edge_lim)
  );

  // busy-indicator selection at end of conversion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_sel_o <= 1'b0;
    else if (eoc_i) busy_sel_o <= ~cnv_i;
  end

endmodule

// File: rtl/adc_cfg_port_chk.sv
module adc_cfg_port_chk #(
  parameter int unsigned CFG_W = 14,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnv_i,
  input logic             eoc_i,
  input logic             sdo_o,
  input logic             sdo_oe_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic             cfg_upd_o,
  input logic             busy_sel_o,
  input logic             sck_fall,
  input logic [CNT_W-1:0] edge_cnt,
  input logic [CNT_W-1:0] edge_lim
);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe_o |-> !sdo_o);

  p_edge_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= edge_lim);

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe_o) |-> $past(sck_fall));

  p_cfg_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o != $past(cfg_o)) |-> cfg_upd_o);

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd_o |=> !cfg_upd_o);

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd_o |-> cfg_o[CFG_W-1]);

  p_busy_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_i |=> (busy_sel_o == !$past(cnv_i)));

endmodule

bind adc_cfg_port adc_cfg_port_chk #(.CFG_W(CFG_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnv_i      (cnv_i),
  .eoc_i      (eoc_i),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .cfg_o      (cfg_o),
  .cfg_upd_o  (cfg_upd_o),
  .busy_sel_o (busy_sel_o),
  .sck_fall   (sck_fall),
  .edge_cnt   (edge_cnt),
  .edge_lim   (edge_lim)
);

// File: tb/adc_cfg_port_tb.sv
`timescale 1ns/1ps
module adc_cfg_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnv_i = 1'b0, sck_i = 1'b0, din_i = 1'b0, eoc_i = 1'b0;
  logic [15:0] result_i = '0;
  logic        sdo_o, sdo_oe_o, cfg_upd_o, busy_sel_o;
  logic [13:0] cfg_o;

  int checks = 0;
  int fails  = 0;
  int strobes = 0;

  always #2.5 clk = ~clk;

  adc_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv_i), .sck_i(sck_i), .din_i(din_i),
    .eoc_i(eoc_i), .result_i(result_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .cfg_o(cfg_o), .cfg_upd_o(cfg_upd_o), .busy_sel_o(busy_sel_o)
  );

  always @(posedge clk) if (rst_n && cfg_upd_o) strobes <= strobes + 1;

  // {result, din word incl. flag in bit 13, sck cycles}
  localparam int NV = 7;
  localparam logic [35:0] VEC [NV] = '{
    {16'hA5C3, 14'h0000, 6'd16},  // flag low: no write (R5)
    {16'h1234, 14'h2001, 6'd16},  // stage readback-on word (R6)
    {16'hFFFF, 14'h0000, 6'd30},  // readback frame, 30 edges (R4)
    {16'h0F0F, 14'h3FFE, 6'd10},  // partial write dropped (R6)
    {16'h8001, 14'h2AAA, 6'd20},  // stage readback-off word
    {16'h7E7E, 14'h0000, 6'd20},  // 16-edge frame, extra edges (R3, R8)
    {16'hC001, 14'h0000, 6'd0}
  };

  logic [13:0] m_active = 14'h0000;
  logic [13:0] m_stage  = 14'h0000;
  logic        m_stvld  = 1'b0;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_frame(input logic [15:0] res, input logic [13:0] dw,
                           input int n);
    int s0;
    logic [29:0] word;
    int lim;
    s0 = strobes;
    result_i = res;
    cnv_i = 1'b1; wait_clk(8);
    cnv_i = 1'b0; wait_clk(8);
    if (m_stvld) begin m_active = m_stage; m_stvld = 1'b0; end
    @(negedge clk);
    check("R7 cfg", cfg_o, m_active);
    check("R7 strobes", strobes - s0, (m_active != 14'h0 && (strobes - s0) != 0) ? 1 : 0);
    word = {res, m_active};
    lim  = m_active[0] ? 30 : 16;
    check("R2 oe", sdo_oe_o, 1);
    check("R2 msb", sdo_o, word[29]);
    for (int k = 1; k <= n; k++) begin
      din_i = (k <= 14) ? dw[14-k] : 1'b0;
      wait_clk(8); sck_i = 1'b1;
      wait_clk(8); sck_i = 1'b0;
      wait_clk(8);
      @(negedge clk);
      if (k < lim) begin
        check(k < 16 ? "R2 oe" : "R4 oe", sdo_oe_o, 1);
        check(k < 16 ? "R2 bit" : "R4 bit", sdo_o, word[29-k]);
      end else begin
        check(k == lim ? (lim == 16 ? "R3 oe" : "R4 oe") : "R8 oe", sdo_oe_o, 0);
        check("R8 sdo", sdo_o, 0);
      end
    end
    din_i = 1'b0;
    wait_clk(8);
    @(negedge clk);
    check("R5 cfg unchanged in phase", cfg_o, m_active);
    if (dw[13] && n >= 14) begin m_stage = dw; m_stvld = 1'b1; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [35:0] v;
    wait_clk(4);
    @(negedge clk);
    check("R1 oe in reset", sdo_oe_o, 0);
    check("R1 cfg in reset", cfg_o, 14'h0000);
    rst_n = 1'b1;
    wait_clk(4);
    @(negedge clk);
    check("R1 sdo", sdo_o, 0);
    check("R1 strobe", cfg_upd_o, 0);
    check("R1 busy", busy_sel_o, 0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      run_frame(v[35:20], v[19:6], int'(v[5:0]));
    end
    check("R7 total strobes", strobes, 2);

    // R9: busy selection follows cnv level at end of conversion
    cnv_i = 1'b0; eoc_i = 1'b1; wait_clk(1); eoc_i = 1'b0;
    @(negedge clk);
    check("R9 busy selected", busy_sel_o, 1);
    cnv_i = 1'b1; wait_clk(8);
    eoc_i = 1'b1; wait_clk(1); eoc_i = 1'b0;
    @(negedge clk);
    check("R9 busy suppressed", busy_sel_o, 0);
    cnv_i = 1'b0; wait_clk(8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule